// File: doc/BRIEF.md
# Two-Channel Bus-Mapped Interval Timer

This block is a memory-mapped down-counting interval timer that sits on an APB slave port. It provides `NCH` channels, two by default. Each channel has a control register, a reload register and a counter register. A shared bank holds a fixed identification word, a configuration word, the interrupt enables, the write-one-to-clear interrupt status and the channel enables. Per-channel bits in the shared words sit at bit `4*c`, so each channel owns a 4-bit field. Only the lowest bit of each field is implemented.

Software loads a first interval straight into the counter and a period into the reload register. It selects 32-bit mode with either the bus clock or an external tick strobe as the count source, and then sets the channel's enable bit. A channel that steps while its count is zero takes the reload value and flags its status bit. The single `irq` output combines every flagged channel whose interrupt is enabled. A reload of all ones gives a full 32-bit wrap, so a channel can also serve as a free-running down-counter.

Top module: `apb_itimer`

## Requirements
- R1: After reset, every channel control, reload and counter register reads zero, the interrupt-enable (0x14), status (0x18) and channel-enable (0x1C) words read zero, and `irq` is low.
- R2: Offset 0x00 reads the constant `ID_VALUE` (default 32'h0A11_0001), and a write there changes nothing. Offset 0x10 reads a mask with bit 4*c set for each implemented channel. Any unmapped offset reads zero.
- R3: Channel c has its control register at 0x20+0x10*c, its reload at 0x24+0x10*c and its counter at 0x28+0x10*c. Control bits [2:0] select the mode (1 = 32-bit timer), and bit 3 selects the count source (1 = bus clock, 0 = `ext_tick`). An enabled channel with control value 0x9 decrements its counter once per cycle.
- R4: An enabled counting channel that steps at count zero loads its reload value and sets its status bit (bit 4*c of 0x18) in that same cycle. After a counter preload of N, the first status set lands N+1 cycles after the enabling write. Later sets follow every R+1 cycles for reload value R.
- R5: `irq` is high exactly when some channel has both its status bit and its interrupt-enable bit (bit 4*c of 0x14) set. A pending status with its enable clear keeps `irq` low.
- R6: Clearing a channel's enable bit (bit 4*c of 0x1C) freezes its counter. Setting the bit again resumes from the frozen value, and a reload value written while the channel is stopped governs the periods that follow.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: With control bit 3 at 0, the counter steps only in cycles where `ext_tick` is high.
- R9: With a mode field other than 1, the channel's counter stays unchanged even when the channel is enabled.
- R10: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address of the register |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always zero |
| ext_tick | input | 1 | Count strobe for channels on the external source |
| irq | output | 1 | Combined interrupt request |

## Verification
Random trials pick a channel, a preload and a reload value. Each trial measures the delay to the first interrupt, which should be the preload plus one, and the gap to the next interrupt, which should be the reload plus one. Off-by-one faults in the zero detection or in the reload step show up as a shifted count. A stop-and-resume pattern separates a counter that holds from one that keeps running or reloads on restart. It also shows whether a reload written while stopped is taken. The external-strobe pattern, with long idle gaps, distinguishes gating on the strobe from counting on every clock. A non-32-bit mode, a masked pending status and zero writes to the status word each show whether a disabled path truly has no effect.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam logic [7:0] OFS_ID   = 8'h00;
    localparam logic [7:0] OFS_CFG  = 8'h10;
    localparam logic [7:0] OFS_IEN  = 8'h14;
    localparam logic [7:0] OFS_STS  = 8'h18;
    localparam logic [7:0] OFS_CEN  = 8'h1C;
    localparam int unsigned CH_BASE_SLOT = 2;     // channel c lives at slot (2+c) of 16 bytes
    localparam logic [3:0] SUB_CTL  = 4'h0;
    localparam logic [3:0] SUB_REL  = 4'h4;
    localparam logic [3:0] SUB_CNT  = 4'h8;
    localparam logic [2:0] MODE_T32 = 3'd1;
    localparam int unsigned FIELD_W = 4;          // bits per channel in shared words
    localparam int unsigned CTL_W   = 4;
endpackage

// File: rtl/itmr_chan.sv
module itmr_chan
    import itmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ext_tick,
    input  logic          wr_ctl,
    input  logic          wr_rel,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    output logic [CTL_W-1:0] ctl,
    output logic [DW-1:0] rel,
    output logic [DW-1:0] cnt,
    output logic          expire
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [DW-1:0]    rel;
        logic [DW-1:0]    cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     step;
    logic     at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        step    = run && (st_q.ctl[2:0] == MODE_T32) && (st_q.ctl[3] || ext_tick);
        expire  = step && at_zero && !wr_cnt;
        if (step) begin
            st_d.cnt = at_zero ? st_q.rel : (st_q.cnt - ONE);
        end
        // a bus write to the counter overrides the step of the same cycle
        if (wr_cnt) st_d.cnt = wdata;
        if (wr_rel) st_d.rel = wdata;
        if (wr_ctl) st_d.ctl = wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;
    assign rel = st_q.rel;
    assign cnt = st_q.cnt;
endmodule

// File: rtl/itmr_shared.sv
module itmr_shared
    import itmr_pkg::*;
#(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ien,
    input  logic           wr_sts,
    input  logic           wr_cen,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] expire,
    output logic [NCH-1:0] run,
    output logic [DW-1:0]  ien_word,
    output logic [DW-1:0]  sts_word,
    output logic [DW-1:0]  cen_word,
    output logic           irq
);
    typedef struct packed {
        logic [NCH-1:0] ien;
        logic [NCH-1:0] sts;
        logic [NCH-1:0] cen;
    } shr_st_t;

    shr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (wr_ien) st_d.ien[c] = wdata[FIELD_W*c];
            if (wr_cen) st_d.cen[c] = wdata[FIELD_W*c];
            if (wr_sts && wdata[FIELD_W*c]) st_d.sts[c] = 1'b0;
            if (expire[c]) st_d.sts[c] = 1'b1;   // a new event wins over a clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ien_word = '0;
        sts_word = '0;
        cen_word = '0;
        for (int c = 0; c < NCH; c++) begin
            ien_word[FIELD_W*c] = st_q.ien[c];
            sts_word[FIELD_W*c] = st_q.sts[c];
            cen_word[FIELD_W*c] = st_q.cen[c];
        end
    end

    assign run = st_q.cen;
    assign irq = |(st_q.sts & st_q.ien);
endmodule

// File: rtl/itmr_rdmux.sv
module itmr_rdmux
    import itmr_pkg::*;
#(
    parameter int unsigned NCH      = 2,
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,
    parameter logic [31:0] ID_VALUE = 32'h0A11_0001
) (
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 ien_word,
    input  logic [DW-1:0]                 sts_word,
    input  logic [DW-1:0]                 cen_word,
    input  logic [NCH-1:0][CTL_W-1:0]     ch_ctl,
    input  logic [NCH-1:0][DW-1:0]        ch_rel,
    input  logic [NCH-1:0][DW-1:0]        ch_cnt,
    output logic [DW-1:0]                 rdata
);
    logic [DW-1:0] cfg_word;

    always_comb begin
        cfg_word = '0;
        for (int c = 0; c < NCH; c++) cfg_word[FIELD_W*c] = 1'b1;
    end

    always_comb begin
        rdata = '0;
        if      (addr == AW'(OFS_ID))  rdata = DW'(ID_VALUE);
        else if (addr == AW'(OFS_CFG)) rdata = cfg_word;
        else if (addr == AW'(OFS_IEN)) rdata = ien_word;
        else if (addr == AW'(OFS_STS)) rdata = sts_word;
        else if (addr == AW'(OFS_CEN)) rdata = cen_word;
        for (int c = 0; c < NCH; c++) begin
            if (addr[AW-1:4] == (AW-4)'(CH_BASE_SLOT + c)) begin
                if (addr[3:0] == SUB_CTL) rdata = DW'(ch_ctl[c]);
                if (addr[3:0] == SUB_REL) rdata = ch_rel[c];
                if (addr[3:0] == SUB_CNT) rdata = ch_cnt[c];
            end
        end
    end
endmodule

// File: rtl/apb_itimer.sv
module apb_itimer
    import itmr_pkg::*;
#(
    parameter int unsigned NCH      = 2,              // 1..8 channels
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,              // must cover 0x20 + 0x10*NCH
    parameter logic [31:0] ID_VALUE = 32'h0A11_0001
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          ext_tick,
    output logic          irq
);
    logic                     bus_wr;
    logic                     wr_ien, wr_sts, wr_cen;
    logic [NCH-1:0]           wr_ctl, wr_rel, wr_cnt;
    logic [NCH-1:0]           run, expire;
    logic [NCH-1:0][CTL_W-1:0] ch_ctl;
    logic [NCH-1:0][DW-1:0]   ch_rel, ch_cnt;
    logic [DW-1:0]            ien_word, sts_word, cen_word;
    logic [DW-1:0]            rd_word;

    assign bus_wr = psel && penable && pwrite;

    always_comb begin
        wr_ien = bus_wr && (paddr == AW'(OFS_IEN));
        wr_sts = bus_wr && (paddr == AW'(OFS_STS));
        wr_cen = bus_wr && (paddr == AW'(OFS_CEN));
        for (int c = 0; c < NCH; c++) begin
            wr_ctl[c] = bus_wr && (paddr[AW-1:4] == (AW-4)'(CH_BASE_SLOT + c)) && (paddr[3:0] == SUB_CTL);
            wr_rel[c] = bus_wr && (paddr[AW-1:4] == (AW-4)'(CH_BASE_SLOT + c)) && (paddr[3:0] == SUB_REL);
            wr_cnt[c] = bus_wr && (paddr[AW-1:4] == (AW-4)'(CH_BASE_SLOT + c)) && (paddr[3:0] == SUB_CNT);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        itmr_chan #(.DW(DW)) u_chan (
            .clk      (pclk),
            .rst_n    (presetn),
            .run      (run[c]),
            .ext_tick (ext_tick),
            .wr_ctl   (wr_ctl[c]),
            .wr_rel   (wr_rel[c]),
            .wr_cnt   (wr_cnt[c]),
            .wdata    (pwdata),
            .ctl      (ch_ctl[c]),
            .rel      (ch_rel[c]),
            .cnt      (ch_cnt[c]),
            .expire   (expire[c])
        );
    end

    itmr_shared #(.NCH(NCH), .DW(DW)) u_shared (
        .clk      (pclk),
        .rst_n    (presetn),
        .wr_ien   (wr_ien),
        .wr_sts   (wr_sts),
        .wr_cen   (wr_cen),
        .wdata    (pwdata),
        .expire   (expire),
        .run      (run),
        .ien_word (ien_word),
        .sts_word (sts_word),
        .cen_word (cen_word),
        .irq      (irq)
    );

    itmr_rdmux #(.NCH(NCH), .DW(DW), .AW(AW), .ID_VALUE(ID_VALUE)) u_rdmux (
        .addr     (paddr),
        .ien_word (ien_word),
        .sts_word (sts_word),
        .cen_word (cen_word),
        .ch_ctl   (ch_ctl),
        .ch_rel   (ch_rel),
        .ch_cnt   (ch_cnt),
        .rdata    (rd_word)
    );

    assign prdata  = (psel && !pwrite) ? rd_word : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   psel,
    input logic                   penable,
    input logic                   pwrite,
    input logic [AW-1:0]          paddr,
    input logic                   pready,
    input logic                   pslverr,
    input logic                   ext_tick,
    input logic                   irq,
    input logic [NCH-1:0][3:0]    ch_ctl,
    input logic [NCH-1:0][DW-1:0] ch_rel,
    input logic [NCH-1:0][DW-1:0] ch_cnt,
    input logic [DW-1:0]          ien_word,
    input logic [DW-1:0]          sts_word,
    input logic [DW-1:0]          cen_word
);
    logic [NCH-1:0] cnt_wr;

    always_comb begin
        for (int c = 0; c < NCH; c++)
            cnt_wr[c] = psel && penable && pwrite && (paddr == AW'(8'h28 + 16*c));
    end

    assert_bus_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_word == '0) |-> !irq);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cen_word[4*c] && ch_ctl[c] == 4'h9 && !cnt_wr[c]) |=>
            (ch_cnt[c] == (($past(ch_cnt[c]) == '0) ? $past(ch_rel[c]) : ($past(ch_cnt[c]) - DW'(1)))));

        assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!cen_word[4*c] && !cnt_wr[c]) |=> $stable(ch_cnt[c]));

        assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_word[4*c]) |-> ($past(ch_cnt[c]) == '0 && $past(cen_word[4*c])));

        assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cen_word[4*c] && ch_ctl[c] == 4'h1 && !ext_tick && !cnt_wr[c]) |=> $stable(ch_cnt[c]));

        assert_mode_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctl[c][2:0] != 3'd1 && !cnt_wr[c]) |=> $stable(ch_cnt[c]));
    end
endmodule

bind apb_itimer itmr_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk      (pclk),
    .rst_n    (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pready   (pready),
    .pslverr  (pslverr),
    .ext_tick (ext_tick),
    .irq      (irq),
    .ch_ctl   (ch_ctl),
    .ch_rel   (ch_rel),
    .ch_cnt   (ch_cnt),
    .ien_word (ien_word),
    .sts_word (sts_word),
    .cen_word (cen_word)
);

// File: tb/sim_apb_itimer.sv
`timescale 1ns/1ps
module sim_apb_itimer;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [31:0] ID_EXP = 32'h0A11_0001;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready, pslverr;
    logic          ext_tick = 1'b0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int bus_bad = 0;

    apb_itimer u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .ext_tick(ext_tick), .irq(irq)
    );

    always #10 pclk = ~pclk;   // 50 MHz

    always @(negedge pclk) if (presetn && (!pready || pslverr)) bus_bad++;

    function automatic logic [7:0] a_ctl(int c); return 8'(8'h20 + 16*c); endfunction
    function automatic logic [7:0] a_rel(int c); return 8'(8'h24 + 16*c); endfunction
    function automatic logic [7:0] a_cnt(int c); return 8'(8'h28 + 16*c); endfunction
    function automatic logic [31:0] chbit(int c); return 32'(1) << (4*c); endfunction
    function automatic int exp_first(int n); return n + 1; endfunction
    // clearing takes two bus cycles after the detect cycle, so the remaining wait is R+1-2
    function automatic int exp_gap(int r); return r - 1; endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(logic [7:0] a, logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1'b1;
        @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge pclk); penable = 1'b1; d = prdata;
        @(negedge pclk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        while (!irq && cyc < 5000) begin @(negedge pclk); cyc++; end
    endtask

    task automatic quiesce();
        apb_wr(8'h1C, 32'h0);
        apb_wr(8'h18, 32'hFFFF_FFFF);
        apb_wr(8'h14, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int cyc;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
        foreach (v[i]) if (i < 9) begin
            logic [7:0] offs [9] = '{8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38};
            apb_rd(offs[i], v2);
            chk(v2 == 0, "R1 reset reg", v2, 0);
        end

        // R2 id, cfg, unmapped
        apb_rd(8'h00, v); chk(v == ID_EXP, "R2 id", v, ID_EXP);
        apb_wr(8'h00, 32'hDEAD_BEEF);
        apb_rd(8'h00, v); chk(v == ID_EXP, "R2 id after write", v, ID_EXP);
        apb_rd(8'h10, v); chk(v == 32'h11, "R2 cfg", v, 32'h11);
        apb_rd(8'h0C, v); chk(v == 0, "R2 unmapped", v, 0);
        apb_rd(8'h64, v); chk(v == 0, "R2 unmapped high", v, 0);

        // R3 register layout and per-cycle decrement
        apb_wr(a_ctl(1), 32'h9); apb_wr(a_rel(1), 32'h1234_5678);
        apb_rd(a_ctl(1), v); chk(v == 32'h9, "R3 ctl readback", v, 32'h9);
        apb_rd(a_rel(1), v); chk(v == 32'h1234_5678, "R3 rel readback", v, 32'h1234_5678);
        apb_wr(a_cnt(1), 32'd1000);
        apb_wr(8'h1C, chbit(1));
        apb_rd(a_cnt(1), v); chk(v == 32'd999, "R3 decrement", v, 32'd999);
        quiesce();

        // R4 random first-interval and period trials
        for (int t = 0; t < 10; t++) begin
            int c = int'($urandom % 2);
            int n = int'($urandom % 40);
            int r = 2 + int'($urandom % 40);
            quiesce();
            apb_wr(a_ctl(c), 32'h9);
            apb_wr(a_rel(c), 32'(r));
            apb_wr(a_cnt(c), 32'(n));
            apb_wr(8'h14, chbit(c));
            apb_wr(8'h1C, chbit(c));
            wait_irq(cyc);
            chk(cyc == exp_first(n), "R4 first interval", 32'(cyc), 32'(exp_first(n)));
            apb_wr(8'h18, chbit(c));
            wait_irq(cyc);
            chk(cyc == exp_gap(r), "R4 period", 32'(cyc), 32'(exp_gap(r)));
        end
        quiesce();

        // R4 full wrap with all-ones reload: counter goes to all ones after zero
        apb_wr(a_ctl(0), 32'h9); apb_wr(a_rel(0), 32'hFFFF_FFFF); apb_wr(a_cnt(0), 32'd0);
        apb_wr(8'h1C, chbit(0));
        apb_rd(a_cnt(0), v); chk(v == 32'hFFFF_FFFF, "R4 wrap reload", v, 32'hFFFF_FFFF);
        quiesce();

        // R5 masking
        apb_wr(a_ctl(0), 32'h9); apb_wr(a_rel(0), 32'd100); apb_wr(a_cnt(0), 32'd2);
        apb_wr(8'h1C, chbit(0));
        repeat (10) @(negedge pclk);
        chk(irq == 1'b0, "R5 masked irq", 32'(irq), 0);
        apb_rd(8'h18, v); chk(v == 32'h1, "R5 pending status", v, 32'h1);
        apb_wr(8'h14, chbit(0));
        chk(irq == 1'b1, "R5 unmasked irq", 32'(irq), 1);
        quiesce();

        // R6 stop, hold, new reload, resume
        apb_wr(a_ctl(0), 32'h9); apb_wr(a_rel(0), 32'd50); apb_wr(a_cnt(0), 32'd500);
        apb_wr(8'h14, chbit(0));
        apb_wr(8'h1C, chbit(0));
        repeat (10) @(negedge pclk);
        apb_wr(8'h1C, 32'h0);
        apb_rd(a_cnt(0), v); chk(v == 32'd488, "R6 stop value", v, 32'd488);
        repeat (30) @(negedge pclk);
        apb_rd(a_cnt(0), v2); chk(v2 == v, "R6 hold", v2, v);
        apb_wr(a_rel(0), 32'd5);
        apb_wr(8'h1C, chbit(0));
        wait_irq(cyc); chk(cyc == exp_first(488), "R6 resume", 32'(cyc), 32'(exp_first(488)));
        apb_wr(8'h18, chbit(0));
        wait_irq(cyc); chk(cyc == exp_gap(5), "R6 new reload", 32'(cyc), 32'(exp_gap(5)));
        quiesce();

        // R8 external tick source
        apb_wr(a_ctl(1), 32'h1); apb_wr(a_rel(1), 32'd7); apb_wr(a_cnt(1), 32'd3);
        apb_wr(8'h14, chbit(1));
        apb_wr(8'h1C, chbit(1));
        repeat (20) @(negedge pclk);
        chk(irq == 1'b0, "R8 no tick irq", 32'(irq), 0);
        apb_rd(a_cnt(1), v); chk(v == 32'd3, "R8 no tick hold", v, 32'd3);
        ext_tick = 1'b1;
        repeat (4) @(negedge pclk);
        ext_tick = 1'b0;
        chk(irq == 1'b1, "R8 tick expiry", 32'(irq), 1);
        apb_rd(a_cnt(1), v); chk(v == 32'd7, "R8 reload", v, 32'd7);

        // R7 write-one-to-clear
        apb_wr(8'h18, 32'h0);
        apb_rd(8'h18, v); chk(v == 32'h10, "R7 zero write keeps", v, 32'h10);
        apb_wr(8'h18, 32'h10);
        apb_rd(8'h18, v); chk(v == 32'h0, "R7 one write clears", v, 32'h0);
        chk(irq == 1'b0, "R7 irq after clear", 32'(irq), 0);
        quiesce();

        // R9 non-32-bit mode stays idle
        apb_wr(a_ctl(0), 32'hA); apb_wr(a_cnt(0), 32'd20);
        apb_wr(8'h14, chbit(0));
        apb_wr(8'h1C, chbit(0));
        repeat (10) @(negedge pclk);
        apb_rd(a_cnt(0), v); chk(v == 32'd20, "R9 mode idle", v, 32'd20);
        chk(irq == 1'b0, "R9 no irq", 32'(irq), 0);
        quiesce();

        // R10 bus response monitor
        chk(bus_bad == 0, "R10 pready/pslverr", 32'(bus_bad), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule